// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block performs the power-on identification of a page-oriented serial flash memory. On a start pulse it runs a fixed sequence of chip-select frames through an external SPI byte serializer (mode 0, eight-bit transfers). The block owns chip select and offers one byte at a time. The serializer answers each byte with a completion strobe and the byte it shifted in.

The sequence begins with an identification frame. The returned vendor and family fields are validated, and the capacity field is decoded into a page-size exponent and a page count. The block then waits a fixed interval and reads the status register. It repeats this wait and read until the device reports ready, or until a poll limit is reached. If the device is ready but configured for the non-binary page size, the block sends a one-frame reprogramming sequence and reports failure. Otherwise it reports success and the decoded geometry.

A single-cycle completion strobe ends every probe. The strobe comes with a pass flag and, on success only, with the geometry.

Top module: `flash_id_probe`

## Requirements
- R1: After start, chip select falls and one frame of four bytes is sent: 0x9F, then three 0xFF fillers. The bytes returned during the first and second fillers are taken as the vendor byte and the device byte. Chip select then rises.
- R2: The part is accepted only if the vendor byte equals 0x1F and device bits 7:5 equal 3'b001. Otherwise the block ends at once after the ID frame with done high and ok low, and sends no further frame.
- R3: Device bits 4:0 map to (shift, pages) as follows: 0x02→(8,512), 0x03→(8,1024), 0x04→(8,2048), 0x05→(8,4096), 0x06→(9,4096), 0x07→(9,8192), 0x08→(9→10,8192) i.e. 0x08→(10,8192). Every other code fails in the same way as R2.
- R4: A status read is one frame of two bytes, 0xD7 then 0xFF. The byte returned during the 0xFF filler is the status byte.
- R5: Each status frame is preceded by exactly CLK_MHZ*POLL_GAP_US clock cycles with chip select high. These cycles are counted from the cycle after chip select rose at the end of the previous frame.
- R6: Status bit 7 set means ready. While it is clear, status frames are repeated with the wait of R5 between them.
- R7: If MAX_POLLS status reads in a row return bit 7 clear, the probe ends with done high and ok low.
- R8: If a ready status has bit 0 clear, the block raises chip select for one cycle. It then sends 0x3D, 0x2A, 0x80, 0xA6 in one frame and ends with done high and ok low.
- R9: Done is high for exactly one cycle per probe, and ok is high only together with done. page_shift and page_count carry the R3 geometry only while done and ok are both high, and read zero at all other times.
- R10: byte_go is a one-cycle pulse given only while chip select is low. The next byte is offered only after byte_done. Chip select rises for at least one cycle between frames.
- R11: A start pulse that arrives while a probe is running has no effect on the frames, timing or result of that probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a probe when the block is idle |
| cs_n | output | 1 | Flash chip select, active low |
| byte_go | output | 1 | One-cycle request to transfer byte_tx |
| byte_tx | output | 8 | Byte to shift out, valid with byte_go |
| byte_done | input | 1 | Serializer completed the requested byte |
| byte_rx | input | 8 | Byte shifted in, valid with byte_done |
| done | output | 1 | One-cycle end-of-probe strobe |
| ok | output | 1 | Probe succeeded, valid with done |
| page_shift | output | 4 | log2 of page size, valid with done and ok |
| page_count | output | 14 | Number of pages, valid with done and ok |

## Verification
The bench holds a behavioural model that emulates the flash on the byte interface. The model predicts, cycle by cycle, chip select, each requested byte, and the completion strobe with its flag and geometry. Any divergence is therefore caught in the very cycle it appears at the ports. A wrong phase or byte index shows up as a misplaced chip-select edge or a wrong opcode byte within one byte time. A wrong wait counter or poll counter shows up as a status frame that starts one cycle early or late, or that is missing. A mis-latched ID or status byte only shows at the final strobe, through the wrong pass flag or the wrong geometry.

// File: rtl/flash_probe_pkg.sv
// Shared constants, phase and frame encodings, and the geometry record for
// the flash identification probe. Assumes an 8-bit serializer interface.
package flash_probe_pkg;
    localparam int BYTE_W  = 8;
    localparam int SHIFT_W = 4;
    localparam int COUNT_W = 14;
    localparam int IDX_W   = 2;

    localparam logic [BYTE_W-1:0] OP_IDENT  = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_STATUS = 8'hD7;
    localparam logic [BYTE_W-1:0] FILLER    = 8'hFF;
    localparam logic [BYTE_W-1:0] VENDOR_OK = 8'h1F;
    localparam logic [2:0]        FAMILY_OK = 3'b001;

    localparam int READY_BIT  = 7;
    localparam int BINARY_BIT = 0;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SELECT, PH_ISSUE, PH_AWAIT, PH_RELEASE, PH_PAUSE, PH_FINISH
    } phase_t;

    typedef enum logic [1:0] {
        FR_IDENT, FR_STATUS, FR_REPROG
    } frame_t;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [COUNT_W-1:0] pages;
    } geom_t;

    // Byte order of the page-size reprogramming frame.
    function automatic logic [BYTE_W-1:0] reprog_byte(input logic [IDX_W-1:0] idx);
        case (idx)
            2'd0:    return 8'h3D;
            2'd1:    return 8'h2A;
            2'd2:    return 8'h80;
            default: return 8'hA6;
        endcase
    endfunction
endpackage

// File: rtl/fp_geom_decode.sv
// Validates the vendor byte and family field of the identification bytes and
// maps the capacity code to page-size exponent and page count.
// Purely combinational; assumes its inputs are held stable by the caller.
module fp_geom_decode
    import flash_probe_pkg::*;
(
    input  logic [BYTE_W-1:0] vendor,
    input  logic [BYTE_W-1:0] device,
    output logic              known,
    output geom_t             geom
);
    // Accept only the expected vendor and family, then decode capacity.
    always_comb begin
        known = 1'b0;
        geom  = '0;
        if (vendor == VENDOR_OK && device[7:5] == FAMILY_OK) begin
            known = 1'b1;
            case (device[4:0])
                5'h02:   geom = '{shift: 4'd8,  pages: 14'd512};
                5'h03:   geom = '{shift: 4'd8,  pages: 14'd1024};
                5'h04:   geom = '{shift: 4'd8,  pages: 14'd2048};
                5'h05:   geom = '{shift: 4'd8,  pages: 14'd4096};
                5'h06:   geom = '{shift: 4'd9,  pages: 14'd4096};
                5'h07:   geom = '{shift: 4'd9,  pages: 14'd8192};
                5'h08:   geom = '{shift: 4'd10, pages: 14'd8192};
                default: known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fp_wait_timer.sv
// Down-counter that measures the idle gap before each status read.
// A load arms it with GAP_CYCLES; while run is high it counts, and expired
// rises in the last of GAP_CYCLES run cycles. Assumes GAP_CYCLES >= 1.
module fp_wait_timer #(
    parameter int GAP_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] remain;

    // Arm on load, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(GAP_CYCLES);
        end else if (run && remain > CW'(1)) begin
            remain <= remain - CW'(1);
        end
    end

    assign expired = run && (remain <= CW'(1));
endmodule

// File: rtl/fp_sequencer.sv
// Frame sequencer of the probe: owns chip select, offers bytes to the
// serializer one at a time, captures the reply bytes and decides the next
// frame. Assumes byte_done arrives only after a byte_go and at most once per byte.
module fp_sequencer
    import flash_probe_pkg::*;
#(
    parameter int MAX_POLLS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  byte_rx,
    input  logic               id_known,
    input  geom_t              id_geom,
    input  logic               timer_expired,
    output logic               cs_n,
    output logic               byte_go,
    output logic [BYTE_W-1:0]  byte_tx,
    output logic [BYTE_W-1:0]  vendor,
    output logic [BYTE_W-1:0]  device,
    output logic               timer_load,
    output logic               timer_run,
    output logic               done,
    output logic               ok,
    output logic [SHIFT_W-1:0] page_shift,
    output logic [COUNT_W-1:0] page_count
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    phase_t           phase;
    frame_t           frame;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [PW-1:0]    polls;
    logic             st_ready;
    logic             st_binary;
    logic             pass;
    geom_t            geom_q;

    // Index of the final byte of the current frame.
    always_comb last_idx = (frame == FR_STATUS) ? 2'd1 : 2'd3;

    // Phase machine, reply capture and end-of-frame decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            frame     <= FR_IDENT;
            idx       <= '0;
            polls     <= '0;
            vendor    <= '0;
            device    <= '0;
            st_ready  <= 1'b0;
            st_binary <= 1'b0;
            pass      <= 1'b0;
            geom_q    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        frame  <= FR_IDENT;
                        idx    <= '0;
                        pass   <= 1'b0;
                        geom_q <= '0;
                        phase  <= PH_SELECT;
                    end
                end
                PH_SELECT: phase <= PH_ISSUE;
                PH_ISSUE:  phase <= PH_AWAIT;
                PH_AWAIT: begin
                    if (byte_done) begin
                        if (frame == FR_IDENT && idx == 2'd1) vendor <= byte_rx;
                        if (frame == FR_IDENT && idx == 2'd2) device <= byte_rx;
                        if (frame == FR_STATUS && idx == 2'd1) begin
                            st_ready  <= byte_rx[READY_BIT];
                            st_binary <= byte_rx[BINARY_BIT];
                        end
                        if (idx == last_idx) begin
                            phase <= PH_RELEASE;
                        end else begin
                            idx   <= idx + 2'd1;
                            phase <= PH_ISSUE;
                        end
                    end
                end
                PH_RELEASE: begin
                    idx <= '0;
                    case (frame)
                        FR_IDENT: begin
                            if (id_known) begin
                                geom_q <= id_geom;
                                polls  <= '0;
                                phase  <= PH_PAUSE;
                            end else begin
                                phase <= PH_FINISH;
                            end
                        end
                        FR_STATUS: begin
                            if (st_ready) begin
                                if (st_binary) begin
                                    pass  <= 1'b1;
                                    phase <= PH_FINISH;
                                end else begin
                                    frame <= FR_REPROG;
                                    phase <= PH_SELECT;
                                end
                            end else if (polls >= PW'(MAX_POLLS)) begin
                                phase <= PH_FINISH;
                            end else begin
                                phase <= PH_PAUSE;
                            end
                        end
                        default: phase <= PH_FINISH;
                    endcase
                end
                PH_PAUSE: begin
                    if (timer_expired) begin
                        frame <= FR_STATUS;
                        polls <= polls + PW'(1);
                        phase <= PH_SELECT;
                    end
                end
                PH_FINISH: phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Byte offered to the serializer for the current frame and index.
    always_comb begin
        case (frame)
            FR_IDENT:  byte_tx = (idx == 2'd0) ? OP_IDENT : FILLER;
            FR_STATUS: byte_tx = (idx == 2'd0) ? OP_STATUS : FILLER;
            default:   byte_tx = reprog_byte(idx);
        endcase
    end

    // Port-level decode of the phase register.
    always_comb begin
        cs_n       = !(phase == PH_SELECT || phase == PH_ISSUE || phase == PH_AWAIT);
        byte_go    = (phase == PH_ISSUE);
        timer_load = (phase == PH_RELEASE);
        timer_run  = (phase == PH_PAUSE);
        done       = (phase == PH_FINISH);
        ok         = done && pass;
        page_shift = ok ? geom_q.shift : '0;
        page_count = ok ? geom_q.pages : '0;
    end
endmodule

// File: rtl/flash_id_probe.sv
// Top of the serial flash identification probe. Ties the sequencer to the
// ID decoder and to the inter-poll wait timer. The wait is CLK_MHZ*POLL_GAP_US
// cycles; the serializer behind byte_go/byte_done runs SPI mode 0, 8 bits.
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int POLL_GAP_US = 10,
    parameter int MAX_POLLS   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               cs_n,
    output logic               byte_go,
    output logic [BYTE_W-1:0]  byte_tx,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  byte_rx,
    output logic               done,
    output logic               ok,
    output logic [SHIFT_W-1:0] page_shift,
    output logic [COUNT_W-1:0] page_count
);
    localparam int GAP_CYCLES = CLK_MHZ * POLL_GAP_US;

    logic [BYTE_W-1:0] vendor;
    logic [BYTE_W-1:0] device;
    logic              id_known;
    geom_t             id_geom;
    logic              timer_load;
    logic              timer_run;
    logic              timer_expired;

    fp_geom_decode u_decode (
        .vendor (vendor),
        .device (device),
        .known  (id_known),
        .geom   (id_geom)
    );

    fp_wait_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .run     (timer_run),
        .expired (timer_expired)
    );

    fp_sequencer #(.MAX_POLLS(MAX_POLLS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .byte_done     (byte_done),
        .byte_rx       (byte_rx),
        .id_known      (id_known),
        .id_geom       (id_geom),
        .timer_expired (timer_expired),
        .cs_n          (cs_n),
        .byte_go       (byte_go),
        .byte_tx       (byte_tx),
        .vendor        (vendor),
        .device        (device),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .done          (done),
        .ok            (ok),
        .page_shift    (page_shift),
        .page_count    (page_count)
    );
endmodule

// File: rtl/fp_probe_checker.sv
// Port-level protocol checks for flash_id_probe, attached by bind.
module fp_probe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        byte_go,
    input logic        byte_done,
    input logic        done,
    input logic        ok,
    input logic [3:0]  page_shift,
    input logic [13:0] page_count
);
    // R10: bytes are requested only inside a frame
    a_r10_go_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |-> !cs_n);

    // R10: a request lasts one cycle and never repeats back to back
    a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |=> !byte_go);

    // R10: a frame closes only after the serializer finished a byte
    a_r10_cs_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(byte_done));

    // R9: completion strobe is a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: pass flag only accompanies the strobe
    a_r9_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> done);

    // R3: reported geometry lies in the decoded range
    a_r3_geom_range: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (page_shift >= 4'd8 && page_shift <= 4'd10 && page_count >= 14'd512));

    // R10: the probe ends with chip select released
    a_r10_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
endmodule

bind flash_id_probe fp_probe_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .byte_go    (byte_go),
    .byte_done  (byte_done),
    .done       (done),
    .ok         (ok),
    .page_shift (page_shift),
    .page_count (page_count)
);

// File: tb/flash_id_probe_tb.sv
// Bench: a flash emulator answers each byte after RLAT cycles, and a queue
// of expected per-cycle port values is compared at every falling edge.
module flash_id_probe_tb;
    localparam int CLK_MHZ     = 250;
    localparam int POLL_GAP_US = 1;
    localparam int MAX_POLLS   = 4;
    localparam int GAP         = CLK_MHZ * POLL_GAP_US;
    localparam int RLAT        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cs_n;
    logic        byte_go;
    logic [7:0]  byte_tx;
    logic        byte_done = 1'b0;
    logic [7:0]  byte_rx = 8'h00;
    logic        done;
    logic        ok;
    logic [3:0]  page_shift;
    logic [13:0] page_count;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int cd = 0;

    logic [7:0]  rx_q[$];
    logic [29:0] exp_q[$];

    always #2 clk = ~clk;

    flash_id_probe #(.CLK_MHZ(CLK_MHZ), .POLL_GAP_US(POLL_GAP_US), .MAX_POLLS(MAX_POLLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .byte_go(byte_go),
        .byte_tx(byte_tx), .byte_done(byte_done), .byte_rx(byte_rx), .done(done),
        .ok(ok), .page_shift(page_shift), .page_count(page_count)
    );

    // Flash emulator: reply RLAT cycles after each byte request.
    always @(negedge clk) begin
        byte_done = 1'b0;
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
                byte_done = 1'b1;
                byte_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
            end
        end
        if (byte_go === 1'b1) cd = RLAT;
    end

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            summary_and_end();
        end
    end

    task automatic push_rec(input logic c, input logic g, input logic [7:0] t,
                            input logic d, input logic k, input logic [3:0] s,
                            input logic [13:0] n);
        exp_q.push_back({c, g, t, d, k, s, n});
    endtask

    task automatic push_frame(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3, input int nb);
        logic [7:0] b[4];
        b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
        push_rec(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0);
        for (int i = 0; i < nb; i++) begin
            push_rec(1'b0, 1'b1, b[i], 1'b0, 1'b0, 4'd0, 14'd0);
            for (int j = 0; j < RLAT; j++) push_rec(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0);
        end
        push_rec(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0);
    endtask

    task automatic push_gap();
        for (int i = 0; i < GAP; i++) push_rec(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0);
    endtask

    task automatic push_fin(input logic k, input logic [3:0] s, input logic [13:0] n);
        push_rec(1'b1, 1'b0, 8'h00, 1'b1, k, s, n);
        push_rec(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0);
    endtask

    task automatic id_frame(input logic [7:0] ven, input logic [7:0] dev);
        push_frame(8'h9F, 8'hFF, 8'hFF, 8'hFF, 4);
        rx_q.push_back(8'h00); rx_q.push_back(ven); rx_q.push_back(dev); rx_q.push_back(8'h00);
    endtask

    task automatic status_frame(input logic [7:0] sts);
        push_gap();
        push_frame(8'hD7, 8'hFF, 8'h00, 8'h00, 2);
        rx_q.push_back(8'h00); rx_q.push_back(sts);
    endtask

    task automatic compare(input logic [29:0] e, input string tag, input int n);
        logic ec, eg, ed, ek;
        logic [7:0] et;
        logic [3:0] es;
        logic [13:0] en;
        logic bad;
        {ec, eg, et, ed, ek, es, en} = e;
        bad = (cs_n !== ec) || (byte_go !== eg) || (eg && byte_tx !== et) ||
              (done !== ed) || (ed && ok !== ek) || (page_shift !== es) || (page_count !== en);
        compared = compared + 1;
        if (bad) begin
            mismatched = mismatched + 1;
            $display("FAIL %s cycle %0d: actual cs=%b go=%b tx=%h done=%b ok=%b sh=%0d pg=%0d expected cs=%b go=%b tx=%h done=%b ok=%b sh=%0d pg=%0d",
                     tag, n, cs_n, byte_go, byte_tx, done, ok, page_shift, page_count,
                     ec, eg, et, ed, ek, es, en);
        end
    endtask

    task automatic run_probe(input string tag, input int extra_start_at);
        int n = 0;
        @(negedge clk);
        start = 1'b1;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            start = (n == extra_start_at);
            compare(exp_q.pop_front(), tag, n);
            n++;
        end
        start = 1'b0;
        rx_q.delete();
    endtask

    initial begin
        logic [7:0]  codes[7];
        logic [3:0]  shs[7];
        logic [13:0] pgs[7];
        codes = '{8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28};
        shs   = '{4'd8, 4'd8, 4'd8, 4'd8, 4'd9, 4'd9, 4'd10};
        pgs   = '{14'd512, 14'd1024, 14'd2048, 14'd4096, 14'd4096, 14'd8192, 14'd8192};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R10: idle state after reset
        compare({1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0, 14'd0}, "R9 R10 reset", 0);

        // R1 R4 R5 R6 R9 R10: good part, one busy poll then ready
        id_frame(8'h1F, 8'h26);
        status_frame(8'h01);
        status_frame(8'h81);
        push_fin(1'b1, 4'd9, 14'd4096);
        run_probe("R1 R4 R5 R6 R9 R10 good", -1);

        // R2: wrong vendor byte
        id_frame(8'h1E, 8'h26);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R2 vendor", -1);

        // R2: wrong family field
        id_frame(8'h1F, 8'h46);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R2 family", -1);

        // R3: capacity codes outside the table
        id_frame(8'h1F, 8'h29);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R3 code 09", -1);
        id_frame(8'h1F, 8'h21);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R3 code 01", -1);

        // R3: every capacity code in the table
        for (int i = 0; i < 7; i++) begin
            id_frame(8'h1F, codes[i]);
            status_frame(8'h81);
            push_fin(1'b1, shs[i], pgs[i]);
            run_probe("R3 decode", -1);
        end

        // R8: ready but non-binary page size
        id_frame(8'h1F, 8'h27);
        status_frame(8'h80);
        push_frame(8'h3D, 8'h2A, 8'h80, 8'hA6, 4);
        for (int i = 0; i < 4; i++) rx_q.push_back(8'h00);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R8 reprogram", -1);

        // R7: never ready within MAX_POLLS reads
        id_frame(8'h1F, 8'h25);
        for (int i = 0; i < MAX_POLLS; i++) status_frame(8'h01);
        push_fin(1'b0, 4'd0, 14'd0);
        run_probe("R7 timeout", -1);

        // R11: extra start while busy changes nothing
        id_frame(8'h1F, 8'h28);
        status_frame(8'h01);
        status_frame(8'h81);
        push_fin(1'b1, 4'd10, 14'd8192);
        run_probe("R11 start ignored", 20);

        summary_and_end();
    end
endmodule